// File: doc/BRIEF.md
# PCM Codec Serial Time-Slot Port

This block is the digital serial side of a voice PCM codec. It has an independent transmit lane and receive lane. The transmit lane takes a parallel 8-bit sample word and shifts it onto a serial line during its time slot, most significant bit first. The receive lane collects eight serial bits from the line and hands the byte to the core with a one-cycle valid strobe. Each lane has its own frame-sync input, which also acts as a time-slot enable.

All logic runs on one fast system clock. The codec master clock, the two data clocks, the sync inputs and the serial data input are brought in through two-flop synchronizers and their edges are detected in the system clock domain. A static mode input selects between two modes. In fixed-data-rate mode the master clock is the bit clock for both lanes. In variable-data-rate mode each lane uses its own data clock, and its sync input must stay high for the whole slot. In fixed mode, a sync pulse one bit long marks a normal frame and a pulse two bits long marks a signaling frame. Each lane goes into standby on its own once its sync has stayed low for a timeout, counted in master-clock cycles. The timeout count depends on the master-clock frequency code.

The serial output comes with an output enable, and an outer pad cell turns these into a tristate pin.

Top module: `pcm_serial_port`

## Requirements
- R1: A transmit slot starts at a bit-clock rising edge where the transmit sync is high after being low at the previous rising edge. In fixed mode the bit clock is the master clock. The word is driven MSB first: bit 7 at the start edge and bit 7-k at the k-th following rising edge, for eight rising edges in total.
- R2: A receive slot starts in the same way on the receive sync. Bits are sampled MSB first on the next eight falling edges of the receive bit clock. After the eighth bit, `rx_valid_o` is high for exactly one system cycle, with the byte on `rx_word_o`.
- R3: `pcm_oe_o` is high from the start edge until the ninth rising edge of the slot and is low at all other times. `pcm_out_o` is 0 whenever `pcm_oe_o` is low.
- R4: The transmit word is latched at the start edge. A change on `tx_word_i` during the slot has no effect on the bits being shifted out.
- R5: In fixed mode, a lane's signaling flag (`tx_sig_o`, and `rx_sig_o` with the received byte) is 1 when the sync is still high at the second rising edge of the slot and 0 when it is not. Both flags are cleared at each slot start.
- R6: With `fixed_mode_i` = 0, the transmit lane is clocked by `tx_dclk_i` and the receive lane by `rx_dclk_i`, and the master clock is not used for the slots. Both signaling flags stay 0.
- R7: In variable mode, if the sync is low at any rising edge before the slot is complete, the slot is abandoned. The transmit enable drops at that edge and no receive strobe is produced.
- R8: Each lane sets its standby output after its sync has been low for LIMIT master-clock rising edges in a row. A high sync clears the count. The two lanes are timed independently.
- R9: LIMIT follows `clk_sel_i`: 0 gives LIMIT_2048K, 1 gives LIMIT_1544K, 2 gives LIMIT_1536K, and 3 is treated as 0.
- R10: A lane leaves standby at its next slot start.
- R11: After reset, `pcm_oe_o`, `rx_valid_o`, both standby outputs and both signaling flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than any codec clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mclk_i | input | 1 | Codec master clock |
| fixed_mode_i | input | 1 | 1 selects fixed-data-rate mode, 0 selects variable-data-rate mode |
| clk_sel_i | input | 2 | Master-clock frequency code used for the standby limit |
| tx_dclk_i | input | 1 | Transmit data clock (variable mode) |
| rx_dclk_i | input | 1 | Receive data clock (variable mode) |
| tx_sync_i | input | 1 | Transmit frame sync / slot enable |
| rx_sync_i | input | 1 | Receive frame sync / slot enable |
| tx_word_i | input | WORD_W | Sample word to transmit |
| pcm_in_i | input | 1 | Serial receive data |
| pcm_out_o | output | 1 | Serial transmit data |
| pcm_oe_o | output | 1 | Output enable for the serial transmit pin |
| tx_sig_o | output | 1 | Signaling flag of the current or last transmit frame |
| tx_standby_o | output | 1 | Transmit lane in standby |
| rx_word_o | output | WORD_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new received byte |
| rx_sig_o | output | 1 | Signaling flag of the received byte |
| rx_standby_o | output | 1 | Receive lane in standby |

## Verification
A broken bit counter or shift register shows up on the serial line within one slot. Bits come out misordered, the output enable stays high past the ninth rising edge, or the receive strobe is missing or repeated. These can all be seen within about ten bit periods of the sync edge. A wrong signaling-flag state is visible one bit period after the start edge on `tx_sig_o`, and with the next strobe on `rx_sig_o`. A standby counter that runs off or picks the wrong limit only becomes visible after the limit has elapsed. So the standby checks look on both sides of the exact limit for each frequency code, and with one lane kept busy while the other lane times out.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [1:0] {
    MCLK_2048K = 2'd0,
    MCLK_1544K = 2'd1,
    MCLK_1536K = 2'd2,
    MCLK_RSVD  = 2'd3
  } mclk_sel_e;
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pcm_standby_timer.sv
module pcm_standby_timer #(
  parameter int LIMIT_2048K = 614400,
  parameter int LIMIT_1544K = 463200,
  parameter int LIMIT_1536K = 460800
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       sync_i,
  input  logic [1:0] sel_i,
  input  logic       wake_i,
  output logic       standby_o
);
  import pcm_pkg::*;

  localparam int MAX_AB = (LIMIT_2048K > LIMIT_1544K) ? LIMIT_2048K : LIMIT_1544K;
  localparam int MAX_L  = (MAX_AB > LIMIT_1536K) ? MAX_AB : LIMIT_1536K;
  localparam int CNT_W  = $clog2(MAX_L + 1);

  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q;
  logic             standby_q;

  always_comb begin
    case (mclk_sel_e'(sel_i))
      MCLK_1544K: limit = CNT_W'(LIMIT_1544K);
      MCLK_1536K: limit = CNT_W'(LIMIT_1536K);
      default:    limit = CNT_W'(LIMIT_2048K);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      standby_q <= 1'b0;
    end else begin
      if (sync_i) begin
        cnt_q <= '0;
      end else if (tick_i && !standby_q) begin
        if (cnt_q == limit - CNT_W'(1)) standby_q <= 1'b1;
        else cnt_q <= cnt_q + CNT_W'(1);
      end
      if (wake_i) begin
        standby_q <= 1'b0;
        cnt_q     <= '0;
      end
    end
  end

  assign standby_o = standby_q;

  // R8
  standby_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(standby_q) |-> $past(!sync_i));

  // R10
  standby_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !standby_q);
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_rise_i,
  input  logic              sync_i,
  input  logic              fixed_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              pcm_o,
  output logic              oe_o,
  output logic              sig_o,
  output logic              start_o
);
  localparam int CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] LAST = CW'(WORD_W);

  logic [WORD_W-1:0] shift_q;
  logic [CW-1:0]     cnt_q;
  logic              active_q, dout_q, sig_q, sync_prev_q;
  logic              start;

  assign start = bit_rise_i && !active_q && sync_i && !sync_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q     <= '0;
      cnt_q       <= '0;
      active_q    <= 1'b0;
      dout_q      <= 1'b0;
      sig_q       <= 1'b0;
      sync_prev_q <= 1'b0;
    end else if (bit_rise_i) begin
      sync_prev_q <= sync_i;
      if (start) begin
        active_q <= 1'b1;
        shift_q  <= word_i << 1;
        dout_q   <= word_i[WORD_W-1];
        cnt_q    <= CW'(1);
        sig_q    <= 1'b0;
      end else if (active_q) begin
        if (cnt_q == LAST) begin
          active_q <= 1'b0;
          dout_q   <= 1'b0;
        end else if (!fixed_i && !sync_i) begin
          active_q <= 1'b0;
          dout_q   <= 1'b0;
        end else begin
          dout_q  <= shift_q[WORD_W-1];
          shift_q <= shift_q << 1;
          cnt_q   <= cnt_q + CW'(1);
          if (fixed_i && cnt_q == CW'(1)) sig_q <= sync_i;
        end
      end
    end
  end

  assign pcm_o   = active_q & dout_q;
  assign oe_o    = active_q;
  assign sig_o   = sig_q;
  assign start_o = start;

  // R1
  tx_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q >= CW'(1) && cnt_q <= LAST));

  // R4
  tx_msb_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> pcm_o == $past(word_i[WORD_W-1]));

  // R6
  tx_var_nosig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fixed_i && $past(!fixed_i) && oe_o && $past(start)) |-> !sig_o);
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_rise_i,
  input  logic              bit_fall_i,
  input  logic              sync_i,
  input  logic              fixed_i,
  input  logic              din_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o,
  output logic              sig_o,
  output logic              start_o
);
  localparam int CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [WORD_W-2:0] shift_q;
  logic [WORD_W-1:0] data_q;
  logic [CW-1:0]     cnt_q;
  logic              active_q, first_q, sig_q, sig_out_q, valid_q, sync_prev_q;
  logic              start;

  assign start = bit_rise_i && !active_q && sync_i && !sync_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q     <= '0;
      data_q      <= '0;
      cnt_q       <= '0;
      active_q    <= 1'b0;
      first_q     <= 1'b0;
      sig_q       <= 1'b0;
      sig_out_q   <= 1'b0;
      valid_q     <= 1'b0;
      sync_prev_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (bit_rise_i) begin
        sync_prev_q <= sync_i;
        if (start) begin
          active_q <= 1'b1;
          first_q  <= 1'b1;
          cnt_q    <= '0;
          sig_q    <= 1'b0;
        end else if (active_q) begin
          if (!fixed_i && !sync_i) active_q <= 1'b0;
          if (first_q) begin
            first_q <= 1'b0;
            sig_q   <= fixed_i & sync_i;
          end
        end
      end else if (bit_fall_i && active_q) begin
        shift_q <= {shift_q[WORD_W-3:0], din_i};
        cnt_q   <= cnt_q + CW'(1);
        if (cnt_q == LAST) begin
          active_q  <= 1'b0;
          data_q    <= {shift_q, din_i};
          sig_out_q <= sig_q;
          valid_q   <= 1'b1;
        end
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign sig_o   = sig_out_q;
  assign start_o = start;

  // R2
  rx_strobe_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  // R2
  rx_done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> !active_q);

  // R6
  rx_var_nosig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !fixed_i && $past(!fixed_i)) |-> !sig_out_q);
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
  parameter int WORD_W      = 8,
  parameter int LIMIT_2048K = 614400,
  parameter int LIMIT_1544K = 463200,
  parameter int LIMIT_1536K = 460800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mclk_i,
  input  logic              fixed_mode_i,
  input  logic [1:0]        clk_sel_i,
  input  logic              tx_dclk_i,
  input  logic              rx_dclk_i,
  input  logic              tx_sync_i,
  input  logic              rx_sync_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              pcm_in_i,
  output logic              pcm_out_o,
  output logic              pcm_oe_o,
  output logic              tx_sig_o,
  output logic              tx_standby_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o,
  output logic              rx_sig_o,
  output logic              rx_standby_o
);
  // bit order: 0 mclk, 1 tx dclk, 2 rx dclk, 3 tx sync, 4 rx sync, 5 serial in
  localparam int NSYNC = 6;

  logic [NSYNC-1:0] raw, lvl;
  logic [2:0]       clk_prev_q, clk_rise, clk_fall;
  logic             tx_rise, rx_rise, rx_fall;
  logic             tx_start, rx_start;

  assign raw = {pcm_in_i, rx_sync_i, tx_sync_i, rx_dclk_i, tx_dclk_i, mclk_i};

  pcm_sync #(.W(NSYNC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_prev_q <= '0;
    else         clk_prev_q <= lvl[2:0];
  end

  assign clk_rise = lvl[2:0] & ~clk_prev_q;
  assign clk_fall = ~lvl[2:0] & clk_prev_q;

  assign tx_rise = fixed_mode_i ? clk_rise[0] : clk_rise[1];
  assign rx_rise = fixed_mode_i ? clk_rise[0] : clk_rise[2];
  assign rx_fall = fixed_mode_i ? clk_fall[0] : clk_fall[2];

  pcm_tx_lane #(.WORD_W(WORD_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_rise_i(tx_rise),
    .sync_i    (lvl[3]),
    .fixed_i   (fixed_mode_i),
    .word_i    (tx_word_i),
    .pcm_o     (pcm_out_o),
    .oe_o      (pcm_oe_o),
    .sig_o     (tx_sig_o),
    .start_o   (tx_start)
  );

  pcm_rx_lane #(.WORD_W(WORD_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_rise_i(rx_rise),
    .bit_fall_i(rx_fall),
    .sync_i    (lvl[4]),
    .fixed_i   (fixed_mode_i),
    .din_i     (lvl[5]),
    .data_o    (rx_word_o),
    .valid_o   (rx_valid_o),
    .sig_o     (rx_sig_o),
    .start_o   (rx_start)
  );

  pcm_standby_timer #(
    .LIMIT_2048K(LIMIT_2048K),
    .LIMIT_1544K(LIMIT_1544K),
    .LIMIT_1536K(LIMIT_1536K)
  ) u_tx_stby (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (clk_rise[0]),
    .sync_i   (lvl[3]),
    .sel_i    (clk_sel_i),
    .wake_i   (tx_start),
    .standby_o(tx_standby_o)
  );

  pcm_standby_timer #(
    .LIMIT_2048K(LIMIT_2048K),
    .LIMIT_1544K(LIMIT_1544K),
    .LIMIT_1536K(LIMIT_1536K)
  ) u_rx_stby (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (clk_rise[0]),
    .sync_i   (lvl[4]),
    .sel_i    (clk_sel_i),
    .wake_i   (rx_start),
    .standby_o(rx_standby_o)
  );

  // R3
  oe_quiet_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pcm_oe_o |-> !pcm_out_o);
endmodule

// File: tb/pcm_serial_port_bench.sv
module pcm_serial_port_bench;
  localparam int LA = 24, LB = 16, LC = 40;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic mclk = 0, txd = 0, rxd = 0, fsx = 0, fsr = 0, din = 0, fixed = 1;
  logic [1:0] sel = 2'd0;
  logic [7:0] word = 8'h00;
  logic pcm_out, pcm_oe, tx_sig, tx_stby, rx_valid, rx_sig, rx_stby;
  logic [7:0] rx_word;

  int checks = 0, errors = 0, got_n = 0, cycles = 0;
  logic [7:0] got_b;
  logic got_s;
  logic cap_d [0:12];
  logic cap_e [0:12];
  logic s_pcm, s_oe;

  always #10 clk_i = ~clk_i;

  pcm_serial_port #(.WORD_W(8), .LIMIT_2048K(LA), .LIMIT_1544K(LB), .LIMIT_1536K(LC))
  u_pcm_serial_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .mclk_i(mclk), .fixed_mode_i(fixed), .clk_sel_i(sel),
    .tx_dclk_i(txd), .rx_dclk_i(rxd), .tx_sync_i(fsx), .rx_sync_i(fsr), .tx_word_i(word),
    .pcm_in_i(din), .pcm_out_o(pcm_out), .pcm_oe_o(pcm_oe), .tx_sig_o(tx_sig),
    .tx_standby_o(tx_stby), .rx_word_o(rx_word), .rx_valid_o(rx_valid), .rx_sig_o(rx_sig),
    .rx_standby_o(rx_stby)
  );

  always @(negedge clk_i) if (rx_valid) begin
    got_n++; got_b = rx_word; got_s = rx_sig;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one bit period of 8 system cycles; samples outputs just before the next rising edge
  task automatic bit_cyc(input logic sx, input logic sr, input logic d,
                         input logic use_m, input logic use_d);
    @(negedge clk_i);
    fsx = sx; fsr = sr; din = d;
    if (use_m) mclk = 1;
    if (use_d) begin txd = 1; rxd = 1; end
    repeat (4) @(negedge clk_i);
    mclk = 0; txd = 0; rxd = 0;
    repeat (3) @(negedge clk_i);
    s_pcm = pcm_out; s_oe = pcm_oe;
  endtask

  task automatic do_frame(input logic [7:0] w, input logic [7:0] b, input logic sig,
                          input int abort_at, input logic [7:0] w2);
    logic var_m;
    var_m = !fixed;
    word = w;
    for (int k = 0; k < 13; k++) begin
      logic s;
      s = (k == 0) || (k == 1 && sig) || (var_m && k < 8 && k < abort_at);
      bit_cyc(s, s, (k < 8) ? b[7-k] : 1'b0, !var_m, var_m);
      if (k == 0) word = w2;
      cap_d[k] = s_pcm; cap_e[k] = s_oe;
    end
  endtask

  task automatic t_reset;
    chk("R11 oe", pcm_oe, 0);
    chk("R11 valid count", got_n, 0);
    chk("R11 tx standby", tx_stby, 0);
    chk("R11 rx standby", rx_stby, 0);
    chk("R11 tx sig", tx_sig, 0);
    chk("R11 rx sig", rx_sig, 0);
  endtask

  task automatic t_fixed_normal;
    int n0;
    n0 = got_n; fixed = 1;
    do_frame(8'hA5, 8'h3C, 0, 99, 8'hA5);
    for (int k = 0; k < 8; k++) chk("R1 tx bit", cap_d[k], (8'hA5 >> (7 - k)) & 1);
    for (int k = 0; k < 8; k++) chk("R3 oe in slot", cap_e[k], 1);
    chk("R3 oe after slot", cap_e[8], 0);
    chk("R3 out low after slot", cap_d[8], 0);
    chk("R2 strobe count", got_n - n0, 1);
    chk("R2 rx byte", got_b, 8'h3C);
    chk("R5 rx sig normal", got_s, 0);
    chk("R5 tx sig normal", tx_sig, 0);
  endtask

  task automatic t_fixed_sig;
    int n0;
    n0 = got_n; fixed = 1;
    do_frame(8'h96, 8'hC1, 1, 99, 8'hFF);
    for (int k = 0; k < 8; k++) chk("R4 latched bit", cap_d[k], (8'h96 >> (7 - k)) & 1);
    chk("R2 strobe count sig", got_n - n0, 1);
    chk("R2 rx byte sig", got_b, 8'hC1);
    chk("R5 rx sig", got_s, 1);
    chk("R5 tx sig", tx_sig, 1);
  endtask

  task automatic t_var;
    int n0;
    n0 = got_n; fixed = 0;
    do_frame(8'h5A, 8'hE7, 0, 99, 8'h5A);
    for (int k = 0; k < 8; k++) chk("R6 tx bit", cap_d[k], (8'h5A >> (7 - k)) & 1);
    chk("R6 oe end", cap_e[8], 0);
    chk("R6 strobe count", got_n - n0, 1);
    chk("R6 rx byte", got_b, 8'hE7);
    chk("R6 rx sig", got_s, 0);
    chk("R6 tx sig", tx_sig, 0);
  endtask

  task automatic t_abort;
    int n0;
    n0 = got_n; fixed = 0;
    do_frame(8'hFF, 8'h81, 0, 4, 8'hFF);
    chk("R7 oe before drop", cap_e[3], 1);
    chk("R7 oe at drop", cap_e[4], 0);
    chk("R7 no strobe", got_n - n0, 0);
    fixed = 1;
  endtask

  task automatic t_sel(input logic [1:0] s, input int lim);
    sel = s;
    bit_cyc(1, 1, 0, 1, 0);
    repeat (lim - 2) bit_cyc(0, 0, 0, 1, 0);
    chk("R9 tx before limit", tx_stby, 0);
    chk("R9 rx before limit", rx_stby, 0);
    repeat (4) bit_cyc(0, 0, 0, 1, 0);
    chk("R9 tx at limit", tx_stby, 1);
    chk("R9 rx at limit", rx_stby, 1);
    bit_cyc(1, 1, 0, 1, 0);
    chk("R10 tx wake", tx_stby, 0);
    chk("R10 rx wake", rx_stby, 0);
    repeat (10) bit_cyc(0, 0, 0, 1, 0);
  endtask

  task automatic t_indep;
    sel = 2'd0;
    bit_cyc(1, 1, 0, 1, 0);
    for (int i = 0; i < LA + 8; i++) bit_cyc(0, (i % 8) == 7, 0, 1, 0);
    chk("R8 tx standby alone", tx_stby, 1);
    chk("R8 rx stays awake", rx_stby, 0);
    bit_cyc(1, 0, 0, 1, 0);
    chk("R10 tx wake alone", tx_stby, 0);
    repeat (10) bit_cyc(0, 0, 0, 1, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk_i);
    rst_ni = 1;
    repeat (4) @(negedge clk_i);
    t_reset;
    t_fixed_normal;
    t_fixed_sig;
    t_var;
    t_abort;
    t_fixed_normal;
    t_sel(2'd0, LA);
    t_sel(2'd1, LB);
    t_sel(2'd2, LC);
    t_sel(2'd3, LA);
    t_indep;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule